// File: doc/BRIEF.md
# Pipelined Shift-and-Add Natural Exponential

This unit computes e^x for an unsigned fixed-point fraction x restricted to [0, ln 2). It uses a restoring digit recurrence. A residual starts at x. At step n the residual is compared against the hard-wired constant ln(1 + 2^-n). When the residual is at least that constant, the constant is subtracted and the running product E is multiplied by (1 + 2^-n). That multiplication is a right shift by n followed by an add. E always lies in [1, 2), so only its fraction is stored and the leading one is implied.

Each step is its own pipeline stage, so a new operand can enter on every clock. A result leaves a fixed number of cycles later, in input order. The step with constant ln 2 can never fire for inputs below ln 2, so it is left out and the steps run from n = 1 to n = NIT. The residual carries more fraction bits than the input. The product carries more fraction bits than the output. A final round-half-up stage narrows the product to the output width and saturates instead of wrapping.

Top module: `exp_sa_unit`

## Requirements
- R1: While rst_n is low, and after it is released, y_vld stays 0 until an operand accepted after the release has travelled the full pipeline. Operands in flight when reset is asserted are discarded.
- R2: Each cycle with x_vld = 1 yields exactly one cycle with y_vld = 1, exactly NIT (default 20) clock edges later, in input order. Back-to-back operands are accepted on every cycle.
- R3: For every x in [0, ln 2) with x read as x / 2^XW, y / 2^YW is within 2 units of 2^-YW of e^x - 1. The defaults are XW = YW = 16.
- R4: For the input x = 0 the output y is exactly 0, meaning e^0 = 1.0 with the implicit one.
- R5: The largest representable input below ln 2 (45426 at XW = 16) meets the R3 bound, and the output does not wrap to a small value.
- R6: If rounding, or the product update, carries past the fraction width, the fraction saturates to all ones.
- R7: Along the pipeline the residual never increases from one stage to the next, and the stored product fraction never decreases.
- R8: Cycles with x_vld = 0 produce no output, whatever value is on x.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset for the valid pipeline |
| x_vld | input | 1 | Operand strobe |
| x | input | XW | Unsigned fraction, value x / 2^XW, below ln 2 |
| y_vld | output | 1 | Result strobe, NIT cycles after x_vld |
| y | output | YW | Fraction of e^x with the leading 1 implied |

## Verification
The hardest cases to reach are inputs near ln 2. There the product approaches 2.0 and the rounding and saturation paths of R5 and R6 may engage. Those inputs make up a thin slice of the domain. The stimulus therefore sweeps every legal input code from 0 to the largest one below ln 2, back to back. It then replays a sparse set of codes with idle cycles between them and garbage on x during those idle cycles. Finally it asserts reset while operands are still in flight, to show that the pipeline flushes.

// File: rtl/exp_sa_pkg.sv
package exp_sa_pkg;

  // Guard fraction width used while building step constants at elaboration
  localparam int GUARD_FW = 61;

  // ln(1 + 2^-sh) as a fraction with fw bits, correctly rounded.
  // Series u - u^2/2 + u^3/3 - ... with u = 2^-sh, computed with GUARD_FW bits.
  function automatic logic [63:0] ln1p_pow2(input int sh, input int fw);
    logic [63:0] acc;
    logic [63:0] term;
    acc = '0;
    for (int k = 1; k <= GUARD_FW; k++) begin
      if (sh * k <= GUARD_FW) begin
        term = (64'd1 << (GUARD_FW - sh * k)) / 64'(k);
        if ((k % 2) == 1) acc = acc + term;
        else              acc = acc - term;
      end
    end
    return (acc + (64'd1 << (GUARD_FW - fw - 1))) >> (GUARD_FW - fw);
  endfunction

endpackage

// File: rtl/exp_sa_stage.sv
module exp_sa_stage
  import exp_sa_pkg::*;
#(
  parameter int LW = 20,
  parameter int PW = 20,
  parameter int SH = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v_i,
  input  logic [LW-1:0] res_i,
  input  logic [PW-1:0] man_i,
  output logic          v_o,
  output logic [LW-1:0] res_o,
  output logic [PW-1:0] man_o
);

  localparam logic [63:0]   KFULL = ln1p_pow2(SH, LW);
  localparam logic [LW-1:0] KSTEP = KFULL[LW-1:0];
  localparam int            MW    = PW + 2;

  logic          take;
  logic [MW-1:0] full;
  logic [MW-1:0] grown;
  logic [LW-1:0] res_n;
  logic [PW-1:0] man_n;
  logic          grown_unused;

  // next state: compare, subtract, shift-and-add with hidden one attached
  always_comb begin
    take  = (res_i >= KSTEP);
    full  = {2'b01, man_i};
    grown = full + (full >> SH);
    res_n = res_i;
    man_n = man_i;
    if (take) begin
      res_n = res_i - KSTEP;
      man_n = grown[MW-1] ? {PW{1'b1}} : grown[PW-1:0];
    end
  end

  assign grown_unused = grown[PW];

  // valid register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  // data registers, enabled by the incoming strobe
  always_ff @(posedge clk) begin
    if (v_i) begin
      res_o <= res_n;
      man_o <= man_n;
    end
  end

endmodule

// File: rtl/exp_sa_round.sv
module exp_sa_round #(
  parameter int PW = 20,
  parameter int YW = 16
) (
  input  logic [PW-1:0] man_i,
  output logic [YW-1:0] y_o
);

  generate
    if (PW > YW) begin : g_narrow
      localparam int DROP = PW - YW;
      logic [PW:0]     biased;
      logic            low_unused;
      always_comb begin
        biased = {1'b0, man_i} + ((PW+1)'(1) << (DROP - 1));
        y_o    = biased[PW] ? {YW{1'b1}} : biased[PW-1 -: YW];
      end
      assign low_unused = ^biased[DROP-1:0];
    end else begin : g_pass
      assign y_o = man_i;
    end
  endgenerate

endmodule

// File: rtl/exp_sa_unit.sv
module exp_sa_unit #(
  parameter int XW  = 16,
  parameter int LW  = 20,
  parameter int PW  = 20,
  parameter int YW  = 16,
  parameter int NIT = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x_vld,
  input  logic [XW-1:0] x,
  output logic          y_vld,
  output logic [YW-1:0] y
);

  logic [NIT:0]         vld_q;
  logic [NIT:0][LW-1:0] res_q;
  logic [NIT:0][PW-1:0] man_q;

  // stage 0: residual is x widened, product fraction is zero (E = 1.0)
  assign vld_q[0] = x_vld;
  assign man_q[0] = '0;
  generate
    if (LW > XW) begin : g_widen
      assign res_q[0] = {x, {(LW-XW){1'b0}}};
    end else begin : g_same
      assign res_q[0] = x;
    end
  endgenerate

  generate
    for (genvar k = 0; k < NIT; k++) begin : g_step
      exp_sa_stage #(
        .LW(LW),
        .PW(PW),
        .SH(k + 1)
      ) u_step (
        .clk  (clk),
        .rst_n(rst_n),
        .v_i  (vld_q[k]),
        .res_i(res_q[k]),
        .man_i(man_q[k]),
        .v_o  (vld_q[k+1]),
        .res_o(res_q[k+1]),
        .man_o(man_q[k+1])
      );
    end
  endgenerate

  exp_sa_round #(
    .PW(PW),
    .YW(YW)
  ) u_round (
    .man_i(man_q[NIT]),
    .y_o  (y)
  );

  assign y_vld = vld_q[NIT];

endmodule

// File: rtl/exp_sa_unit_chk.sv
module exp_sa_unit_chk #(
  parameter int LW  = 20,
  parameter int PW  = 20,
  parameter int YW  = 16,
  parameter int NIT = 20
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 y_vld,
  input logic [YW-1:0]        y,
  input logic [NIT:0]         v,
  input logic [NIT:0][LW-1:0] res,
  input logic [NIT:0][PW-1:0] man
);

  localparam int CW = $clog2(NIT + 1) + 1;
  logic [CW-1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (int'(since_rst) < NIT) since_rst <= since_rst + 1'b1;
  end

  // R1
  no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_vld |-> (int'(since_rst) >= NIT));

  // R6
  sat_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (y_vld && (&man[NIT][PW-1 -: YW])) |-> (&y));

  generate
    for (genvar k = 0; k < NIT; k++) begin : g_k
      // R7
      res_nonincr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v[k+1] |-> (res[k+1] <= $past(res[k])));
      // R7
      man_nondecr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v[k+1] |-> (man[k+1] >= $past(man[k])));
      // R4
      zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v[k+1] && $past(res[k] == '0) && $past(man[k] == '0)) |-> (man[k+1] == '0));
      // R2
      vld_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v[k+1] |-> $past(v[k]));
    end
  endgenerate

endmodule

bind exp_sa_unit exp_sa_unit_chk #(
  .LW (LW),
  .PW (PW),
  .YW (YW),
  .NIT(NIT)
) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .y_vld(y_vld),
  .y    (y),
  .v    (vld_q),
  .res  (res_q),
  .man  (man_q)
);

// File: tb/exp_sa_unit_bench.sv
module exp_sa_unit_bench;

  localparam int XW  = 16;
  localparam int YW  = 16;
  localparam int NIT = 20;

  logic          clk;
  logic          rst_n;
  logic          x_vld;
  logic [XW-1:0] x;
  logic          y_vld;
  logic [YW-1:0] y;

  int checks   = 0;
  int fails    = 0;
  int pushed   = 0;
  int received = 0;
  int maxx;
  logic [XW-1:0] exp_q [$];

  exp_sa_unit u_exp_sa_unit (
    .clk  (clk),
    .rst_n(rst_n),
    .x_vld(x_vld),
    .x    (x),
    .y_vld(y_vld),
    .y    (y)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic bad(input string req, input string what, input int act, input int expv);
    fails++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
  endtask

  task automatic check_val(input logic [XW-1:0] xv, input logic [YW-1:0] yv);
    real ref_y;
    real diff;
    checks++;
    ref_y = ($exp(real'(xv) / 65536.0) - 1.0) * 65536.0;
    diff  = real'(yv) - ref_y;
    if (diff < 0.0) diff = -diff;
    if (xv == 0) begin
      if (yv != 0) bad("R4", "e^0", int'(yv), 0);
    end else if (int'(xv) == maxx) begin
      if (diff > 2.0) bad("R5", "top input", int'(yv), int'(ref_y + 0.5));
    end else if (diff > 2.0) begin
      $display("FAIL R3 x=%0d actual=%0d expected=%0d", xv, yv, int'(ref_y + 0.5));
      fails++;
    end
  endtask

  // scoreboard: outputs sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && y_vld) begin
      received++;
      if (exp_q.size() == 0) begin
        checks++;
        bad("R8", "output without operand", int'(y), -1);
      end else begin
        check_val(exp_q.pop_front(), y);
      end
    end
  end

  task automatic drive(input logic v, input logic [XW-1:0] xv);
    x_vld = v;
    x     = xv;
    if (v) begin
      exp_q.push_back(xv);
      pushed++;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, XW'(16'hA5C3 ^ i));
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    maxx  = int'($floor(0.6931471805599453 * 65536.0));
    rst_n = 1'b0;
    x_vld = 1'b0;
    x     = '0;
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    checks++;
    if (y_vld !== 1'b0) bad("R1", "y_vld in reset", int'(y_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: single operand latency is exactly NIT edges
    drive(1'b1, XW'(12345));
    x_vld = 1'b0;
    for (int i = 1; i <= NIT; i++) begin
      checks++;
      if (y_vld !== (i == NIT)) bad("R2", "latency slot", int'(y_vld), int'(i == NIT));
      if (i < NIT) @(negedge clk);
    end
    idle(4);

    // R3 R4 R5 R2: full back-to-back sweep of legal codes
    for (int xi = 0; xi <= maxx; xi++) drive(1'b1, XW'(xi));
    idle(NIT + 4);

    // R8: sparse operands with garbage on x during idle cycles
    for (int xi = 0; xi <= maxx; xi += 997) begin
      drive(1'b1, XW'(xi));
      idle(xi % 3 + 1);
    end
    drive(1'b1, XW'(maxx));
    drive(1'b1, XW'(0));
    idle(NIT + 4);

    // R1: reset with operands in flight flushes them
    for (int i = 0; i < 5; i++) drive(1'b1, XW'(1000 * i + 7));
    x_vld = 1'b0;
    rst_n = 1'b0;
    exp_q.delete();
    pushed = pushed - 5;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NIT + 3; i++) begin
      checks++;
      if (y_vld !== 1'b0) bad("R1", "output after flush", int'(y_vld), 0);
      idle(1);
    end

    // R2: every accepted operand produced exactly one result
    checks++;
    if (received != pushed) bad("R2", "result count", received, pushed);
    checks++;
    if (exp_q.size() != 0) bad("R2", "results missing", exp_q.size(), 0);

    summary();
  end

endmodule